// File: doc/BRIEF.md
# BCH8 Error Location Corrector

This block finishes the correction of one 512-byte sector after a BCH syndrome decoder has run. It receives the decoder's results as four 32-bit words: a status word whose bits 13:10 hold the number of errors found, and three result words that, together with status bits 23:16, carry up to eight packed 13-bit error locations. On a start pulse it latches these words and walks the locations one by one. Each location is adjusted, checked against the sector size and, when in range, turned into a single-bit flip through a byte-wide read-modify-write port on the sector buffer.

When the run ends the block raises a one-cycle done pulse with the number of bits actually flipped. An error count above eight cannot be corrected; the block then reports an uncorrectable flag without touching the buffer, which the surrounding logic uses to start its erased-page check. A count of zero finishes at once with a result of zero.

Top module: `errLocCorrector`

## Requirements
- R1: After reset, done, busy, memRdEn and memWrEn are all low.
- R2: The error count n is statusWord[13:10]; when n is 0 the block raises done in the first cycle after the start edge with fixCount 0 and uncorrectable 0, and makes no buffer access.
- R3: When n is 9 to 15 the block raises done in the first cycle after the start edge with uncorrectable 1 and fixCount 0, and makes no buffer access.
- R4: The eight 13-bit locations are taken as: L0 = resWord1[12:0], L1 = resWord1[25:13], L2 = {resWord2[6:0], resWord1[31:26]}, L3 = resWord2[19:7], L4 = {resWord3[0], resWord2[31:20]}, L5 = resWord3[13:1], L6 = resWord3[26:14], L7 = {statusWord[23:16], resWord3[31:27]}.
- R5: Each location has its bits 1 and 0 inverted to give the bit address A; the byte written is memAddr = A>>3 and memWrData is the byte read at that address with bit A&7 inverted.
- R6: A location whose bit address A exceeds 4096 is skipped: no buffer access and no increment of fixCount, yet it still uses up one of the n slots. A = 4096 is applied (byte index 512, bit 0).
- R7: For 1 <= n <= 8, slot k (k from 0) reads in cycle 2k+1 and writes in cycle 2k+2 after the start edge, the write cycle carrying the same memAddr as the read; done is raised in cycle 2n+1 with fixCount equal to the number of applied locations.
- R8: Only locations L0 to L(n-1) are used; the rest have no effect on the buffer.
- R9: busy is high from the cycle after an accepted start through the done cycle; a start raised while busy, including in the done cycle, is ignored.
- R10: done lasts exactly one cycle; fixCount and uncorrectable keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a correction run with the words on the inputs |
| statusWord | input | 32 | Decoder status: error count in 13:10, top location bits in 23:16 |
| resWord1 | input | 32 | First packed location word |
| resWord2 | input | 32 | Second packed location word |
| resWord3 | input | 32 | Third packed location word |
| memRdData | input | 8 | Byte returned by the buffer one cycle after memRdEn |
| memAddr | output | 10 | Byte index into the sector buffer |
| memRdEn | output | 1 | Read strobe of the read-modify-write |
| memWrEn | output | 1 | Write strobe of the read-modify-write |
| memWrData | output | 8 | Corrected byte |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fixCount | output | 4 | Number of bits flipped in the last run |
| uncorrectable | output | 1 | Last run had more than eight errors |

## Verification
Two pairs of functions can meet in one cycle. The write of one slot and the read of the next slot may address the same byte, so locations are placed in one byte and also repeated exactly, and the buffer image must show both flips, or none when a bit is flipped twice. A new start may arrive in the very cycle the done pulse is high; the bench raises a start with a different count there and in the middle of runs, and judges that no second run begins, busy drops, and fixCount and uncorrectable stay unchanged.

// File: rtl/errLocPkg.sv
package errLocPkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // latch words and clear run state
    logic rdPhase;  // first cycle of a slot
    logic wrPhase;  // second cycle of a slot
    logic step;     // move to the next slot
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_FIN
  } corrState_t;

endpackage

// File: rtl/errLocCtrl.sv
module errLocCtrl
  import errLocPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        countZero,
  input  logic        countOver,
  input  logic        slotLast,
  output ctlStrobes_t ctl,
  output logic        busy,
  output logic        done
);

  corrState_t state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.load  = 1'b1;
          nextState = (countZero || countOver) ? ST_FIN : ST_RD;
        end
      end
      ST_RD: begin
        ctl.rdPhase = 1'b1;
        nextState   = ST_WR;
      end
      ST_WR: begin
        ctl.wrPhase = 1'b1;
        if (slotLast) begin
          nextState = ST_FIN;
        end else begin
          ctl.step  = 1'b1;
          nextState = ST_RD;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/errLocDatapath.sv
module errLocDatapath
  import errLocPkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int LOC_W        = 13,
  parameter int MAX_ERR      = 8,
  parameter int WORD_W       = 32,
  parameter int CNT_W        = 4,
  parameter int CNT_LSB      = 10,
  parameter int STAT_LOC_LSB = 16,
  localparam int PACK_W      = MAX_ERR * LOC_W,
  localparam int STAT_LOC_W  = PACK_W - 3 * WORD_W,
  localparam int IDX_W       = LOC_W - 3,
  localparam int SLOT_W      = $clog2(MAX_ERR),
  localparam int BIT_LIMIT   = SECTOR_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [WORD_W-1:0] statusWord,
  input  logic [WORD_W-1:0] resWord1,
  input  logic [WORD_W-1:0] resWord2,
  input  logic [WORD_W-1:0] resWord3,
  input  logic [7:0]        memRdData,
  output logic              countZero,
  output logic              countOver,
  output logic              slotLast,
  output logic [IDX_W-1:0]  memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  output logic [CNT_W-1:0]  fixCount,
  output logic              uncorrectable
);

  logic [PACK_W-1:0] packReg;
  logic [CNT_W-1:0]  cntReg;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  countIn;
  logic [LOC_W-1:0]  locArr [MAX_ERR];
  logic [LOC_W-1:0]  adjLoc;
  logic              locOk;

  // Count classification straight from the incoming status word
  assign countIn   = statusWord[CNT_LSB +: CNT_W];
  assign countZero = (countIn == '0);
  assign countOver = (countIn > CNT_W'(MAX_ERR));

  // Fixed-width slices of the latched packed location vector
  for (genvar k = 0; k < MAX_ERR; k++) begin : g_loc
    assign locArr[k] = packReg[k*LOC_W +: LOC_W];
  end

  // Invert the two low bits, then range check against the sector size
  assign adjLoc   = locArr[slot] ^ LOC_W'(3);
  assign locOk    = ({1'b0, adjLoc} <= (LOC_W+1)'(BIT_LIMIT));
  assign memAddr  = adjLoc[LOC_W-1:3];
  assign memRdEn  = ctl.rdPhase && locOk;
  assign memWrEn  = ctl.wrPhase && locOk;
  assign memWrData = memRdData ^ (8'b1 << adjLoc[2:0]);
  assign slotLast = ((CNT_W'(slot) + CNT_W'(1)) == cntReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      packReg       <= '0;
      cntReg        <= '0;
      slot          <= '0;
      fixCount      <= '0;
      uncorrectable <= 1'b0;
    end else begin
      if (ctl.load) begin
        packReg       <= {statusWord[STAT_LOC_LSB +: STAT_LOC_W], resWord3, resWord2, resWord1};
        cntReg        <= countIn;
        slot          <= '0;
        fixCount      <= '0;
        uncorrectable <= countOver;
      end
      if (ctl.step) slot <= slot + SLOT_W'(1);
      if (ctl.wrPhase && locOk) fixCount <= fixCount + CNT_W'(1);
    end
  end

endmodule

// File: rtl/errLocCorrector.sv
module errLocCorrector
  import errLocPkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int LOC_W        = 13,
  parameter int MAX_ERR      = 8,
  parameter int WORD_W       = 32,
  parameter int CNT_W        = 4,
  localparam int IDX_W       = LOC_W - 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] statusWord,
  input  logic [WORD_W-1:0] resWord1,
  input  logic [WORD_W-1:0] resWord2,
  input  logic [WORD_W-1:0] resWord3,
  input  logic [7:0]        memRdData,
  output logic [IDX_W-1:0]  memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  fixCount,
  output logic              uncorrectable
);

  ctlStrobes_t ctl;
  logic        countZero;
  logic        countOver;
  logic        slotLast;

  errLocCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .countZero (countZero),
    .countOver (countOver),
    .slotLast  (slotLast),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done)
  );

  errLocDatapath #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .LOC_W        (LOC_W),
    .MAX_ERR      (MAX_ERR),
    .WORD_W       (WORD_W),
    .CNT_W        (CNT_W)
  ) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .statusWord    (statusWord),
    .resWord1      (resWord1),
    .resWord2      (resWord2),
    .resWord3      (resWord3),
    .memRdData     (memRdData),
    .countZero     (countZero),
    .countOver     (countOver),
    .slotLast      (slotLast),
    .memAddr       (memAddr),
    .memRdEn       (memRdEn),
    .memWrEn       (memWrEn),
    .memWrData     (memWrData),
    .fixCount      (fixCount),
    .uncorrectable (uncorrectable)
  );

endmodule

// File: rtl/errLocChecker.sv
module errLocChecker #(
  parameter int IDX_W        = 10,
  parameter int CNT_W        = 4,
  parameter int SECTOR_BYTES = 512,
  parameter int MAX_ERR      = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             memRdEn,
  input logic             memWrEn,
  input logic [IDX_W-1:0] memAddr,
  input logic [CNT_W-1:0] fixCount,
  input logic             uncorrectable
);

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ($past(memRdEn) && $stable(memAddr))); // R7

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> memWrEn); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRdEn && !memWrEn)); // R9

  AST_UNCORR_NO_FIX: assert property (@(posedge clk) disable iff (!rstN)
    (done && uncorrectable) |-> (fixCount == '0)); // R3

  AST_FIX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (fixCount <= CNT_W'(MAX_ERR))); // R6

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memAddr <= IDX_W'(SECTOR_BYTES))); // R6

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(fixCount) && $stable(uncorrectable))); // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy); // R9

endmodule

bind errLocCorrector errLocChecker #(
  .IDX_W        (IDX_W),
  .CNT_W        (CNT_W),
  .SECTOR_BYTES (SECTOR_BYTES),
  .MAX_ERR      (MAX_ERR)
) i_errLocChecker (
  .clk           (clk),
  .rstN          (rstN),
  .start         (start),
  .busy          (busy),
  .done          (done),
  .memRdEn       (memRdEn),
  .memWrEn       (memWrEn),
  .memAddr       (memAddr),
  .fixCount      (fixCount),
  .uncorrectable (uncorrectable)
);

// File: tb/test_errLocCorrector.sv
module test_errLocCorrector;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_N      = 513;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] statusWord = '0;
  logic [31:0] resWord1 = '0;
  logic [31:0] resWord2 = '0;
  logic [31:0] resWord3 = '0;
  logic [7:0]  memRdData;
  logic [9:0]  memAddr;
  logic        memRdEn;
  logic        memWrEn;
  logic [7:0]  memWrData;
  logic        busy;
  logic        done;
  logic [3:0]  fixCount;
  logic        uncorrectable;

  logic [7:0] mem    [MEM_N];
  logic [7:0] refMem [MEM_N];
  int checks = 0;
  int failures = 0;
  int rdCnt = 0;
  bit finished = 0;

  errLocCorrector i_errLocCorrector (
    .clk (clk), .rstN (rstN), .start (start),
    .statusWord (statusWord), .resWord1 (resWord1), .resWord2 (resWord2), .resWord3 (resWord3),
    .memRdData (memRdData), .memAddr (memAddr), .memRdEn (memRdEn), .memWrEn (memWrEn),
    .memWrData (memWrData), .busy (busy), .done (done), .fixCount (fixCount),
    .uncorrectable (uncorrectable)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Sector buffer model: one-cycle read latency, write at the edge
  always @(posedge clk) begin
    if (memRdEn) begin
      rdCnt <= rdCnt + 1;
      if (memAddr < 10'(MEM_N)) memRdData <= mem[memAddr];
      else memRdData <= 8'hxx;
    end
    if (memWrEn && memAddr < 10'(MEM_N)) mem[memAddr] <= memWrData;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] rawLoc(input int k, input logic [31:0] w1, w2, w3, st);
    case (k)
      0: return w1[12:0];
      1: return w1[25:13];
      2: return {w2[6:0], w1[31:26]};
      3: return w2[19:7];
      4: return {w3[0], w2[31:20]};
      5: return w3[13:1];
      6: return w3[26:14];
      default: return {st[23:16], w3[31:27]};
    endcase
  endfunction

  // One run; pokeAt raises an extra start in that cycle after the start edge (0 = none)
  task automatic runCase(input logic [31:0] w1, w2, w3, st, input int pokeAt, input string tag);
    int n, expFix, expCyc, cyc, bad;
    logic [12:0] a;
    logic [3:0] fixSeen;
    logic uncSeen;
    n = int'(st[13:10]);
    expFix = 0;
    if (n >= 1 && n <= 8) begin
      for (int k = 0; k < n; k++) begin
        a = rawLoc(k, w1, w2, w3, st) ^ 13'd3;
        if (a <= 13'd4096) begin
          refMem[a >> 3][a[2:0]] = ~refMem[a >> 3][a[2:0]];
          expFix++;
        end
      end
      expCyc = 2 * n + 1;
    end else begin
      expCyc = 1;
    end
    @(negedge clk);
    rdCnt = 0;
    resWord1 = w1; resWord2 = w2; resWord3 = w3; statusWord = st;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    forever begin
      if (cyc == pokeAt) begin
        start = 1'b1;
        statusWord = st ^ 32'h0000_3C00;
      end
      if (done || cyc >= 200) break;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    check(cyc == expCyc, (n == 0) ? "R2" : (n > 8) ? "R3" : "R7", {tag, " done cycle"}, cyc, expCyc);
    check(fixCount == 4'(expFix), "R6", {tag, " fixCount"}, int'(fixCount), expFix);
    check(uncorrectable == (n > 8), "R3", {tag, " uncorrectable"}, int'(uncorrectable), int'(n > 8));
    fixSeen = fixCount;
    uncSeen = uncorrectable;
    @(negedge clk);
    start = 1'b0;
    // R9 R10: poke in the done cycle must not restart; done is a single pulse
    check(!done && !busy, "R9", {tag, " quiet after done"}, int'({done, busy}), 0);
    @(negedge clk);
    check(fixCount == fixSeen && uncorrectable == uncSeen, "R10", {tag, " result held"},
          int'({uncorrectable, fixCount}), int'({uncSeen, fixSeen}));
    check(rdCnt == expFix, "R6", {tag, " buffer reads"}, rdCnt, expFix);
    bad = 0;
    for (int i = 0; i < MEM_N; i++) if (mem[i] !== refMem[i]) bad++;
    // R5 R8: buffer image holds exactly the expected flips
    check(bad == 0, "R5", {tag, " buffer image mismatching bytes"}, bad, 0);
  endtask

  // Pack eight locations into words per R4
  task automatic packRun(input logic [12:0] l0, l1, l2, l3, l4, l5, l6, l7,
                         input logic [3:0] n, input int pokeAt, input string tag);
    logic [103:0] p;
    logic [31:0] st;
    p = {l7, l6, l5, l4, l3, l2, l1, l0};
    st = 32'h0;
    st[23:16] = p[103:96];
    st[13:10] = n;
    st[31:24] = 8'hA5;
    st[9:0]   = 10'h2B7;
    runCase(p[31:0], p[63:32], p[95:64], st, pokeAt, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    logic [31:0] w1, w2, w3, st;
    seedDummy = $urandom(32'd7031);
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = 8'($urandom);
      refMem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(!done && !busy && !memRdEn && !memWrEn, "R1", "reset outputs",
          int'({done, busy, memRdEn, memWrEn}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !busy, "R1", "idle after reset", int'({done, busy}), 0);

    // R2: zero count, words full of in-range locations
    runCase(32'h1234_5678, 32'h0BAD_F00D, 32'h7777_1111, 32'h00AA_0000, 0, "R2 zero");
    // R3: counts above eight
    runCase(32'h0000_0010, 32'h0000_0020, 32'h0000_0030, 32'h0000_2400, 0, "R3 nine");
    runCase(32'h0000_0010, 32'h0000_0020, 32'h0000_0030, 32'h0000_3C00, 0, "R3 fifteen");
    // R4: all eight slots, slot 7 fed by status bits
    packRun(13'd5, 13'd100, 13'd777, 13'd1500, 13'd2222, 13'd3001, 13'd3900, 13'd4090, 4'd8, 0, "R4 eight");
    // R6: boundary 4096 applied (raw 4099), 4097 skipped (raw 4098), and a high one skipped
    packRun(13'd4099, 13'd4098, 13'd8191, 13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 4'd3, 0, "R6 boundary");
    // R5: two locations in one byte, then one repeated (cancels)
    packRun(13'd80, 13'd85, 13'd200, 13'd200, 13'd0, 13'd0, 13'd0, 13'd0, 4'd4, 0, "R5 same byte");
    // R8: count 2, other slots hold in-range addresses that must not be used
    packRun(13'd16, 13'd24, 13'd32, 13'd40, 13'd48, 13'd56, 13'd64, 13'd72, 4'd2, 0, "R8 partial");
    // R9: extra start mid-run and exactly in the done cycle
    packRun(13'd300, 13'd301, 13'd302, 13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 4'd3, 3, "R9 mid poke");
    packRun(13'd900, 13'd901, 13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 4'd2, 5, "R9 done poke");
    runCase(32'h0, 32'h0, 32'h0, 32'h0000_0000, 1, "R9 zero poke");

    // Constrained random runs (R4 R5 R6 R7 R8)
    for (int r = 0; r < 40; r++) begin
      w1 = $urandom; w2 = $urandom; w3 = $urandom; st = $urandom;
      if (r % 5 != 4) st[13:10] = 4'(1 + ($urandom % 8));
      runCase(w1, w2, w3, st, ((r % 7) == 3) ? 2 : 0, "R7 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule